// File: doc/BRIEF.md
# Iterative multiply-divide unit with hi/lo result registers

This block is a sequential integer multiply and divide engine. It keeps its results in two local registers, hi and lo, and does not return them on a single result port. A start pulse launches one of four operations on two operand words: signed or unsigned multiply, and signed or unsigned divide. The engine then takes one radix-2 step per clock. A multiply leaves the upper half of the double-width product in hi and the lower half in lo. A divide leaves the remainder in hi and the quotient in lo.

The processor reads hi or lo through a read port that holds off while an operation is running. It can also load either register directly with a write strobe. Error conditions do not trap. Divide by zero and overflow appear as status flags that the engine raises when it signals done, and they hold until the next accepted start. Signed operations work on operand magnitudes and correct the result signs at the end. Division truncates toward zero.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, busy_o, done_o, div_zero_o and ovf_o are 0, and reading hi or lo returns 0.
- R2: With op_i = 2'b00 (unsigned multiply), hi receives bits [2W-1:W] and lo receives bits [W-1:0] of the unsigned product of src_a_i and src_b_i.
- R3: With op_i = 2'b01 (signed multiply), hi:lo receives the two's-complement product of the operands.
- R4: With op_i = 2'b10 (unsigned divide), lo receives the quotient of src_a_i by src_b_i and hi receives the remainder.
- R5: With op_i = 2'b11 (signed divide), the quotient is truncated toward zero and the remainder carries the sign of the dividend (quotient in lo, remainder in hi).
- R6: A start seen while idle raises busy_o on the next cycle. busy_o stays high for exactly WIDTH+1 cycles. done_o is a single-cycle pulse in the first cycle after busy_o falls.
- R7: A divide with a zero divisor leaves hi and lo unchanged. It sets div_zero_o together with done_o, and div_zero_o holds until the next accepted start.
- R8: A signed divide of the most negative value by -1 sets ovf_o with done_o and returns quotient = dividend and remainder = 0.
- R9: A multiply sets ovf_o with done_o when the product does not fit in WIDTH bits. For an unsigned multiply this means hi is nonzero. For a signed multiply it means hi is not the sign extension of lo.
- R10: While idle, wr_hi_i or wr_lo_i loads wr_data_i into hi or lo respectively, and the new value can be read on the next cycle.
- R11: While busy_o is high, writes to hi and lo and further start pulses are ignored.
- R12: rd_valid_o is 0 while busy_o is high. Otherwise rd_valid_o equals rd_req_i, and rd_data_o returns hi when rd_sel_hi_i is 1 and lo when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch an operation (taken only when idle) |
| op_i | input | 2 | 00 unsigned mul, 01 signed mul, 10 unsigned div, 11 signed div |
| src_a_i | input | WIDTH | Multiplicand or dividend |
| src_b_i | input | WIDTH | Multiplier or divisor |
| wr_hi_i | input | 1 | Load hi from wr_data_i |
| wr_lo_i | input | 1 | Load lo from wr_data_i |
| wr_data_i | input | WIDTH | Data for direct loads |
| rd_req_i | input | 1 | Read request |
| rd_sel_hi_i | input | 1 | 1 selects hi, 0 selects lo |
| rd_valid_o | output | 1 | Read data valid (held off while busy) |
| rd_data_o | output | WIDTH | Selected register, 0 when not valid |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last operation was a divide by zero |
| ovf_o | output | 1 | Last operation overflowed |

## Verification
The bench builds the block with WIDTH = 32. At that width the reference model can use native 64-bit arithmetic, and the corner operands that matter are all in reach: the most negative word, all-ones, and -1 as a divisor. The run covers products that overflow and products that fit, and all four sign combinations of signed division. Because the iteration count is 32, the 33-cycle busy window is checked at its real length. Writes and starts issued during a divide by zero show whether they were blocked, since that divide does not overwrite hi or lo.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  // op_i encoding: bit 1 selects divide, bit 0 selects signed
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mdu_op_e;

  function automatic logic op_is_div(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(input logic [1:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/mdu_sign_pre.sv
module mdu_sign_pre #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] mag_a_o,
  output logic [WIDTH-1:0] mag_b_o,
  output logic             neg_lo_o,
  output logic             neg_hi_o,
  output logic             div_zero_o,
  output logic             div_ovf_o
);
  import mdu_pkg::*;

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic sgn_a, sgn_b, is_div;

  always_comb begin
    is_div     = op_is_div(op_i);
    sgn_a      = op_is_signed(op_i) & a_i[WIDTH-1];
    sgn_b      = op_is_signed(op_i) & b_i[WIDTH-1];
    mag_a_o    = sgn_a ? (~a_i + 1'b1) : a_i;
    mag_b_o    = sgn_b ? (~b_i + 1'b1) : b_i;
    // quotient or product negated when the operand signs differ
    neg_lo_o   = sgn_a ^ sgn_b;
    // remainder follows the dividend; a product is negated as a whole
    neg_hi_o   = is_div ? sgn_a : (sgn_a ^ sgn_b);
    div_zero_o = is_div & (b_i == '0);
    div_ovf_o  = (op_i == OP_DIVS) & (a_i == MOST_NEG) & (&b_i);
  end

endmodule

// File: rtl/mdu_iter_engine.sv
module mdu_iter_engine #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             div_mode_i,
  input  logic [WIDTH-1:0] mag_a_i,
  input  logic [WIDTH-1:0] mag_b_i,
  output logic [WIDTH-1:0] raw_hi_o,
  output logic [WIDTH-1:0] raw_lo_o
);

  // upper accumulator carries one guard bit for the carry or borrow
  logic [WIDTH:0]   upr_q, upr_d;
  logic [WIDTH-1:0] lwr_q, lwr_d;
  logic [WIDTH-1:0] opd_q, opd_d;
  logic             upd_en;

  logic [WIDTH:0]   add_sum;
  logic [WIDTH:0]   shl_rem;
  logic [WIDTH:0]   trial;

  always_comb begin
    upd_en  = load_i | step_i;
    add_sum = {1'b0, upr_q[WIDTH-1:0]} + (lwr_q[0] ? {1'b0, opd_q} : '0);
    shl_rem = {upr_q[WIDTH-1:0], lwr_q[WIDTH-1]};
    trial   = shl_rem - {1'b0, opd_q};
    upr_d   = upr_q;
    lwr_d   = lwr_q;
    opd_d   = opd_q;
    if (load_i) begin
      upr_d = '0;
      lwr_d = mag_a_i;
      opd_d = mag_b_i;
    end else if (div_mode_i) begin
      // restoring step: keep the trial difference only when it is not negative
      if (!trial[WIDTH]) begin
        upr_d = trial;
        lwr_d = {lwr_q[WIDTH-2:0], 1'b1};
      end else begin
        upr_d = shl_rem;
        lwr_d = {lwr_q[WIDTH-2:0], 1'b0};
      end
    end else begin
      // shift-add step: conditionally add, then shift the pair right
      upr_d = {1'b0, add_sum[WIDTH:1]};
      lwr_d = {add_sum[0], lwr_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upr_q <= '0;
      lwr_q <= '0;
      opd_q <= '0;
    end else if (upd_en) begin
      upr_q <= upr_d;
      lwr_q <= lwr_d;
      opd_q <= opd_d;
    end
  end

  assign raw_hi_o = upr_q[WIDTH-1:0];
  assign raw_lo_o = lwr_q;

endmodule

// File: rtl/mdu_sign_post.sv
module mdu_sign_post #(
  parameter int WIDTH = 32
) (
  input  logic             div_mode_i,
  input  logic             signed_mode_i,
  input  logic             neg_lo_i,
  input  logic             neg_hi_i,
  input  logic [WIDTH-1:0] raw_hi_i,
  input  logic [WIDTH-1:0] raw_lo_i,
  output logic [WIDTH-1:0] res_hi_o,
  output logic [WIDTH-1:0] res_lo_o,
  output logic             mul_ovf_o
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] prod;

  always_comb begin
    prod = {raw_hi_i, raw_lo_i};
    if (neg_lo_i) prod = ~prod + 1'b1;
    if (div_mode_i) begin
      res_lo_o = neg_lo_i ? (~raw_lo_i + 1'b1) : raw_lo_i;
      res_hi_o = neg_hi_i ? (~raw_hi_i + 1'b1) : raw_hi_i;
    end else begin
      res_lo_o = prod[WIDTH-1:0];
      res_hi_o = prod[PW-1:WIDTH];
    end
    if (signed_mode_i)
      mul_ovf_o = (prod[PW-1:WIDTH] != {WIDTH{prod[WIDTH-1]}});
    else
      mul_ovf_o = (prod[PW-1:WIDTH] != '0);
  end

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_req_i,
  input  logic             rd_sel_hi_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_zero_o,
  output logic             ovf_o
);
  import mdu_pkg::*;

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] STEPS = CNT_W'(WIDTH);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [WIDTH-1:0] mag_a, mag_b, raw_hi, raw_lo, res_hi, res_lo;
  logic             pre_neg_lo, pre_neg_hi, pre_dz, pre_dovf, mul_ovf;

  logic             busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       op_q, op_d;
  logic             neg_lo_q, neg_lo_d, neg_hi_q, neg_hi_d;
  logic             pend_dz_q, pend_dz_d, pend_dovf_q, pend_dovf_d;
  logic             flag_dz_q, flag_dz_d, flag_ovf_q, flag_ovf_d;
  logic [WIDTH-1:0] hi_q, hi_d, lo_q, lo_d;
  logic             hi_en, lo_en, accept, step, fin;

  mdu_sign_pre #(.WIDTH(WIDTH)) u_pre (
    .op_i       (op_i),
    .a_i        (src_a_i),
    .b_i        (src_b_i),
    .mag_a_o    (mag_a),
    .mag_b_o    (mag_b),
    .neg_lo_o   (pre_neg_lo),
    .neg_hi_o   (pre_neg_hi),
    .div_zero_o (pre_dz),
    .div_ovf_o  (pre_dovf)
  );

  mdu_iter_engine #(.WIDTH(WIDTH)) u_eng (
    .clk        (clk),
    .rst_n      (rst_q),
    .load_i     (accept),
    .step_i     (step),
    .div_mode_i (op_is_div(op_q)),
    .mag_a_i    (mag_a),
    .mag_b_i    (mag_b),
    .raw_hi_o   (raw_hi),
    .raw_lo_o   (raw_lo)
  );

  mdu_sign_post #(.WIDTH(WIDTH)) u_post (
    .div_mode_i    (op_is_div(op_q)),
    .signed_mode_i (op_is_signed(op_q)),
    .neg_lo_i      (neg_lo_q),
    .neg_hi_i      (neg_hi_q),
    .raw_hi_i      (raw_hi),
    .raw_lo_i      (raw_lo),
    .res_hi_o      (res_hi),
    .res_lo_o      (res_lo),
    .mul_ovf_o     (mul_ovf)
  );

  // next-state logic
  always_comb begin
    accept      = start_i & ~busy_q;
    step        = busy_q & (cnt_q != '0);
    fin         = busy_q & (cnt_q == '0);
    busy_d      = busy_q;
    cnt_d       = cnt_q;
    op_d        = op_q;
    neg_lo_d    = neg_lo_q;
    neg_hi_d    = neg_hi_q;
    pend_dz_d   = pend_dz_q;
    pend_dovf_d = pend_dovf_q;
    flag_dz_d   = flag_dz_q;
    flag_ovf_d  = flag_ovf_q;
    done_d      = fin;
    if (accept) begin
      busy_d      = 1'b1;
      cnt_d       = STEPS;
      op_d        = op_i;
      neg_lo_d    = pre_neg_lo;
      neg_hi_d    = pre_neg_hi;
      pend_dz_d   = pre_dz;
      pend_dovf_d = pre_dovf;
      flag_dz_d   = 1'b0;
      flag_ovf_d  = 1'b0;
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
    end else if (fin) begin
      busy_d     = 1'b0;
      flag_dz_d  = pend_dz_q;
      flag_ovf_d = op_is_div(op_q) ? pend_dovf_q : mul_ovf;
    end
    // hi/lo: results on completion, direct loads only while idle
    hi_en = (fin & ~pend_dz_q) | (~busy_q & wr_hi_i);
    lo_en = (fin & ~pend_dz_q) | (~busy_q & wr_lo_i);
    hi_d  = fin ? res_hi : wr_data_i;
    lo_d  = fin ? res_lo : wr_data_i;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      cnt_q       <= '0;
      op_q        <= OP_MULU;
      neg_lo_q    <= 1'b0;
      neg_hi_q    <= 1'b0;
      pend_dz_q   <= 1'b0;
      pend_dovf_q <= 1'b0;
      flag_dz_q   <= 1'b0;
      flag_ovf_q  <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      done_q      <= done_d;
      cnt_q       <= cnt_d;
      op_q        <= op_d;
      neg_lo_q    <= neg_lo_d;
      neg_hi_q    <= neg_hi_d;
      pend_dz_q   <= pend_dz_d;
      pend_dovf_q <= pend_dovf_d;
      flag_dz_q   <= flag_dz_d;
      flag_ovf_q  <= flag_ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign div_zero_o = flag_dz_q;
  assign ovf_o      = flag_ovf_q;
  assign rd_valid_o = rd_req_i & ~busy_q;
  assign rd_data_o  = rd_valid_o ? (rd_sel_hi_i ? hi_q : lo_q) : '0;

  // R6: an accepted start makes the unit busy on the next cycle
  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_q)
    (start_i && !busy_o) |=> busy_o);

  // R6: completion is a single pulse that directly follows a busy cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11: hi and lo stay frozen while busy unless the result lands
  a_r11_hilo_frozen_busy: assert property (@(posedge clk) disable iff (!rst_q)
    busy_o |=> (($stable(hi_q) && $stable(lo_q)) || done_o));

  // R7: a divide by zero completes without touching hi or lo
  a_r7_dz_keeps_hilo: assert property (@(posedge clk) disable iff (!rst_q)
    (done_o && div_zero_o) |-> ($stable(hi_q) && $stable(lo_q)));

  // R8: divide-by-zero and overflow never report together
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({div_zero_o, ovf_o}));

endmodule

// File: tb/test_mdu_hilo.sv
module test_mdu_hilo;

  localparam int CLK_P = 10;
  localparam int W     = 32;
  localparam int WDOG  = 200000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] a, b, wdata;
  logic         wr_hi, wr_lo, rd_req, rd_sel;
  logic         rd_valid, busy, done, dz, ovf;
  logic [W-1:0] rd_data;

  mdu_hilo #(.WIDTH(W)) i_mdu_hilo (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .src_a_i(a), .src_b_i(b), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .wr_data_i(wdata), .rd_req_i(rd_req), .rd_sel_hi_i(rd_sel),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy),
    .done_o(done), .div_zero_o(dz), .ovf_o(ovf)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // reference model state
  logic         m_busy, m_done, m_dz, m_ovf, p_dz, p_ovf;
  int           m_cnt;
  logic [W-1:0] m_hi, m_lo, p_hi, p_lo;
  string        data_tag, p_tag, ovf_tag, p_ovf_tag;

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d",
               tag, what, act, exp, cycles);
    end
  endtask

  // compute the pending result at an accepted start (R2..R5, R7..R9)
  task automatic model_launch(input logic [1:0] o, input logic [W-1:0] x,
                              input logic [W-1:0] y);
    logic [2*W-1:0]      pu;
    logic signed [2*W-1:0] ps;
    logic signed [W-1:0] sx, sy;
    p_dz = 1'b0; p_ovf = 1'b0; p_hi = m_hi; p_lo = m_lo;
    sx = x; sy = y;
    case (o)
      2'b00: begin
        pu = {{W{1'b0}}, x} * {{W{1'b0}}, y};
        p_hi = pu[2*W-1:W]; p_lo = pu[W-1:0];
        p_ovf = (pu[2*W-1:W] != '0);
        p_tag = "R2"; p_ovf_tag = "R9";
      end
      2'b01: begin
        ps = 64'(sx) * 64'(sy);
        p_hi = ps[2*W-1:W]; p_lo = ps[W-1:0];
        p_ovf = (ps[2*W-1:W] != {W{ps[W-1]}});
        p_tag = "R3"; p_ovf_tag = "R9";
      end
      2'b10: begin
        p_ovf_tag = "R7";
        if (y == '0) begin p_dz = 1'b1; p_tag = "R7,R11"; end
        else begin p_lo = x / y; p_hi = x % y; p_tag = "R4"; end
      end
      default: begin
        p_ovf_tag = "R8";
        if (y == '0) begin p_dz = 1'b1; p_tag = "R7,R11"; end
        else if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) begin
          p_lo = x; p_hi = '0; p_ovf = 1'b1; p_tag = "R8";
        end else begin
          p_lo = sx / sy; p_hi = sx % sy; p_tag = "R5";
        end
      end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dz = 0; m_ovf = 0; m_cnt = 0;
      m_hi = '0; m_lo = '0; data_tag = "R1"; ovf_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt > 0) m_cnt--;
        else begin
          m_busy = 0; m_done = 1;
          m_dz = p_dz; m_ovf = p_ovf; ovf_tag = p_ovf_tag;
          if (!p_dz) begin m_hi = p_hi; m_lo = p_lo; end
          data_tag = p_tag;
        end
      end else begin
        if (wr_hi) begin m_hi = wdata; data_tag = "R10"; end
        if (wr_lo) begin m_lo = wdata; data_tag = "R10"; end
        if (start) begin
          m_busy = 1; m_cnt = W; m_dz = 0; m_ovf = 0;
          model_launch(op, a, b);
        end
      end
    end
  end

  // compare every cycle, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    cycles++;
    if (rst_n) begin
      chk(W'(busy),     W'(m_busy), "R6,R11", "busy");
      chk(W'(done),     W'(m_done), "R6", "done");
      chk(W'(dz),       W'(m_dz),   "R7", "div_zero");
      chk(W'(ovf),      W'(m_ovf),  ovf_tag, "ovf");
      chk(W'(rd_valid), W'(rd_req & ~m_busy), "R12", "rd_valid");
      if (rd_req && !m_busy)
        chk(rd_data, rd_sel ? m_hi : m_lo, data_tag, rd_sel ? "hi" : "lo");
    end
    if (cycles > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // alternate the read selection so both registers are compared
  always @(negedge clk) begin
    if (!rst_n) rd_sel <= 1'b0;
    else rd_sel <= ~rd_sel;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] x,
                        input logic [W-1:0] y);
    @(negedge clk);
    start = 1; op = o; a = x; b = y;
    @(negedge clk);
    start = 0;
    wait_idle();
  endtask

  task automatic write_hl(input logic hi_sel, input logic [W-1:0] v);
    @(negedge clk);
    wr_hi = hi_sel; wr_lo = ~hi_sel; wdata = v;
    @(negedge clk);
    wr_hi = 0; wr_lo = 0;
    @(negedge clk);
  endtask

  // divide by zero with a write and a second start issued while busy (R7, R11)
  task automatic dz_with_interference(input logic [1:0] o);
    @(negedge clk);
    start = 1; op = o; a = 32'd1234; b = '0;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    wr_hi = 1; wr_lo = 1; wdata = 32'hDEAD_BEEF;
    start = 1; op = 2'b00; a = 32'd3; b = 32'd3;
    @(negedge clk);
    wr_hi = 0; wr_lo = 0; start = 0;
    wait_idle();
  endtask

  initial begin
    rst_n = 0; start = 0; op = 0; a = 0; b = 0;
    wr_hi = 0; wr_lo = 0; wdata = 0; rd_req = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);   // R1: idle reads and flags
    write_hl(1'b1, 32'h1234_5678);  // R10
    write_hl(1'b0, 32'h9ABC_DEF0);
    run_op(2'b00, 32'd3, 32'd5);                 // R2
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R2, R9
    run_op(2'b01, 32'hFFFF_FFFD, 32'd5);         // R3
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000); // R3, R9
    run_op(2'b01, 32'h7FFF_FFFF, 32'd2);         // R9 signed overflow
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R3
    run_op(2'b10, 32'd100, 32'd7);               // R4
    run_op(2'b10, 32'hFFFF_FFFF, 32'd3);         // R4
    run_op(2'b10, 32'd5, 32'd10);                // R4
    run_op(2'b11, 32'hFFFF_FFF9, 32'd2);         // R5 -7/2
    run_op(2'b11, 32'd7, 32'hFFFF_FFFE);         // R5 7/-2
    run_op(2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE); // R5 -7/-2
    run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF); // R8
    run_op(2'b11, 32'h8000_0000, 32'd1);         // R5
    dz_with_interference(2'b10);                 // R7, R11
    dz_with_interference(2'b11);
    rd_req = 0;
    run_op(2'b00, 32'd9, 32'd9);                 // R12 with no request
    rd_req = 1;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule